// File: doc/BRIEF.md
# Frequency Sweep and Modulation Unit

This block changes the 11-bit pitch word of a single tone channel at a programmable rate. In sweep mode each step adds or subtracts a right-shifted copy of the present pitch, so the tone glides up or down. If an upward glide would pass the top of the 11-bit range, the block asks for the channel to be shut off. In modulation mode each step adds a signed entry from a 32-entry table to the pitch that software last wrote. This gives vibrato or arbitrary pitch contours. Walking off the end of the table either parks on the last entry or wraps to the first, as software selects.

The next pitch is always computed one step ahead and held until the step timer expires. At that moment the held value becomes the live pitch and the following value is computed at once. The step timer counts ticks of an input clock enable. One step lasts `interval` units, where a unit is `UNIT_FAST` or `UNIT_SLOW` ticks as the clock-select bit chooses. An interval of zero freezes the pitch. A channel start strobe rearms the timer and rewinds the table. Software can write the control byte while a step is in progress; the new period takes effect at once only when it is shorter than the time still remaining.

Top module: `freq_sweep_mod`

## Requirements
- R1: After reset `cur_freq` is 0 and `kill` is 0.
- R2: A pulse on `freq_we` loads `freq_wdata` into `cur_freq` one cycle later and also makes it the written pitch that modulation mode uses.
- R3: In sweep mode (`mod_func`=0) the staged value is P + (P >> shift) when the direction bit (control bit 3) is 1, and P − (P >> shift) when it is 0. P is the pitch that is current when the value is staged, and shift is control bits 2..0. The staged value becomes `cur_freq` at the next step expiry.
- R4: When a sweep staging gives a value above 2047, `kill` pulses high for one cycle after the staging edge, and `cur_freq` changes no further until the next start.
- R5: In modulation mode (`mod_func`=1) the staged value is (written pitch + table[index]) mod 2048. The table entry is an 8-bit two's-complement value.
- R6: The table index advances by one at each modulation staging. After entry 31 it goes back to 0 when `mod_rep`=1 and stays at 31 when `mod_rep`=0.
- R7: The step length is interval × `UNIT_FAST` ticks when control bit 7 is 0, and interval × `UNIT_SLOW` ticks when it is 1. The interval is control bits 6..4. An interval of 0 stops all pitch changes.
- R8: A control byte write replaces the remaining step count only when the new period is shorter. Otherwise the running step finishes unchanged and the new period applies from the next step.
- R9: `start` reloads the full step period, stages a new value, and uses table index 0 for that staging. The first expiry therefore comes exactly one period of ticks after `start`.
- R10: The step timer advances only on cycles with `tick` high. With `tick` low the pitch holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable for the step timer |
| swp_we | input | 1 | Control byte write strobe |
| swp_data | input | 8 | Control byte: [7] clock select, [6:4] interval, [3] direction, [2:0] shift |
| mod_en | input | 1 | Pitch modification enable |
| mod_func | input | 1 | 0 = sweep, 1 = table modulation |
| mod_rep | input | 1 | Wrap the table index after entry 31 |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 5 | Table write address |
| tbl_data | input | 8 | Table entry, two's complement |
| freq_we | input | 1 | Pitch write strobe |
| freq_wdata | input | 11 | Pitch written by software |
| start | input | 1 | Channel start strobe |
| cur_freq | output | 11 | Live pitch word |
| kill | output | 1 | One-cycle request to disable the channel |

## Verification
A pitch write shows on `cur_freq` one cycle after its edge. A shutoff request shows on `kill` one cycle after the staging edge, whether that edge is the start strobe or an expiry. With `tick` held high, a step expiry lands exactly N edges after the start edge, where N is the period in ticks. The bench reads the pitch at edge N−1, where it must still hold its old value, and again at edge N, where it must have changed. When a shorter period is written, the count restarts from the write edge, so the change falls exactly that many edges later. All values are read at the falling edge that follows the edge in question.

// File: rtl/freq_sweep_mod.sv
module freq_sweep_mod #(
  parameter int FW        = 11,
  parameter int TW        = 8,
  parameter int DEPTH     = 32,
  parameter int UNIT_FAST = 19200,
  parameter int UNIT_SLOW = 153600
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     swp_we,
  input  logic [7:0]               swp_data,
  input  logic                     mod_en,
  input  logic                     mod_func,
  input  logic                     mod_rep,
  input  logic                     tbl_we,
  input  logic [$clog2(DEPTH)-1:0] tbl_addr,
  input  logic [TW-1:0]            tbl_data,
  input  logic                     freq_we,
  input  logic [FW-1:0]            freq_wdata,
  input  logic                     start,
  output logic [FW-1:0]            cur_freq,
  output logic                     kill
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(7 * UNIT_SLOW + 1);

  logic          clk_sel, dir;
  logic [2:0]    ivl, shf;
  logic [FW-1:0] wfreq, staged;
  logic [AW-1:0] idx;
  logic          run;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tbl [DEPTH];

  logic [CW-1:0] per, new_per;
  assign per     = CW'(ivl) * (clk_sel ? CW'(UNIT_SLOW) : CW'(UNIT_FAST));
  assign new_per = CW'(swp_data[6:4]) * (swp_data[7] ? CW'(UNIT_SLOW) : CW'(UNIT_FAST));

  logic active, shorten, expire, stage;
  assign active  = run & mod_en & (ivl != 3'd0);
  assign shorten = swp_we & (new_per < cnt);
  assign expire  = ~start & ~shorten & tick & active & (cnt <= CW'(1));
  assign stage   = mod_en & (start | (freq_we & run) | expire);

  logic [FW-1:0] base, mbase, mod_sum;
  logic [FW:0]   base_x, sw_sum;
  logic [AW-1:0] use_idx, nxt_idx;
  logic          ovf;

  assign base    = freq_we ? freq_wdata : (expire ? staged : cur_freq);
  assign mbase   = freq_we ? freq_wdata : wfreq;
  assign base_x  = {1'b0, base};
  assign sw_sum  = dir ? base_x + (base_x >> shf) : base_x - (base_x >> shf);
  assign use_idx = start ? '0 : idx;
  assign mod_sum = mbase + FW'($signed(tbl[use_idx]));
  assign nxt_idx = (use_idx == AW'(DEPTH - 1)) ? (mod_rep ? '0 : use_idx) : use_idx + AW'(1);
  assign ovf     = ~mod_func & sw_sum[FW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (tbl_we) begin
      tbl[tbl_addr] <= tbl_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {clk_sel, ivl, dir, shf} <= '0;
    end else if (swp_we) begin
      {clk_sel, ivl, dir, shf} <= swp_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_freq <= '0;
      wfreq    <= '0;
      staged   <= '0;
      idx      <= '0;
      run      <= 1'b0;
      kill     <= 1'b0;
    end else begin
      if (freq_we) begin
        cur_freq <= freq_wdata;
        wfreq    <= freq_wdata;
      end else if (expire) begin
        cur_freq <= staged;
      end
      if (stage) staged <= mod_func ? mod_sum : sw_sum[FW-1:0];
      if (stage && mod_func) idx <= nxt_idx;
      else if (start)        idx <= '0;
      kill <= stage & ovf;
      if (stage && ovf) run <= 1'b0;
      else if (start)   run <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (start)            cnt <= per;
    else if (shorten)          cnt <= new_per;
    else if (tick && active)   cnt <= (cnt <= CW'(1)) ? per : cnt - CW'(1);
  end
endmodule

module freq_sweep_mod_chk #(
  parameter int FW    = 11,
  parameter int AW    = 5,
  parameter int DEPTH = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          freq_we,
  input logic [FW-1:0] freq_wdata,
  input logic          mod_func,
  input logic          mod_rep,
  input logic          start,
  input logic [FW-1:0] cur_freq,
  input logic          kill,
  input logic [AW-1:0] idx
);
  p_wr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    freq_we |=> cur_freq == $past(freq_wdata));

  p_kill_sweep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> $past(!mod_func));

  p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == AW'(DEPTH - 1) && !mod_rep && !start) |=> idx == AW'(DEPTH - 1));

  p_start_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> idx <= AW'(1));

  p_cur_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_freq) |-> $past(freq_we | tick));
endmodule

bind freq_sweep_mod freq_sweep_mod_chk #(.FW(FW), .AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .freq_we(freq_we), .freq_wdata(freq_wdata),
  .mod_func(mod_func), .mod_rep(mod_rep), .start(start), .cur_freq(cur_freq),
  .kill(kill), .idx(idx)
);

// File: tb/sim_freq_sweep_mod.sv
`timescale 1ns/1ps
module sim_freq_sweep_mod;
  localparam int UF = 3, US = 10;

  logic clk = 0, rst_n = 0, tick = 0;
  logic swp_we = 0, mod_en = 0, mod_func = 0, mod_rep = 0;
  logic [7:0] swp_data = 0;
  logic tbl_we = 0;
  logic [4:0] tbl_addr = 0;
  logic [7:0] tbl_data = 0;
  logic freq_we = 0, start = 0;
  logic [10:0] freq_wdata = 0;
  logic [10:0] cur_freq;
  logic kill;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] tv [32];

  always #2.5 clk = ~clk;

  freq_sweep_mod #(.UNIT_FAST(UF), .UNIT_SLOW(US)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .swp_we(swp_we), .swp_data(swp_data),
    .mod_en(mod_en), .mod_func(mod_func), .mod_rep(mod_rep), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data), .freq_we(freq_we), .freq_wdata(freq_wdata),
    .start(start), .cur_freq(cur_freq), .kill(kill));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_swp(logic [7:0] d);
    swp_data = d; swp_we = 1; cyc(1); swp_we = 0;
  endtask

  task automatic wr_freq(int f);
    freq_wdata = 11'(f); freq_we = 1; cyc(1); freq_we = 0;
  endtask

  task automatic go(bit func, bit rep);
    mod_func = func; mod_rep = rep; mod_en = 1; start = 1; cyc(1); start = 0;
  endtask

  function automatic int sw_nxt(int f, bit d, int sh);
    return d ? f + (f >> sh) : f - (f >> sh);
  endfunction

  function automatic int md(int f, logic [7:0] t);
    return (f + int'($signed(t))) & 2047;
  endfunction

  function automatic int per(logic [7:0] b);
    return int'(b[6:4]) * (b[7] ? US : UF);
  endfunction

  initial begin
    #1ms;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk("R1 cur", cur_freq, 0);
    chk("R1 kill", kill, 0);
    tick = 1;

    wr_freq(321);
    chk("R2 write load", cur_freq, 321);

    // R3/R4 directed: 1000 up by 1/4, P=6
    mod_en = 0; wr_swp(8'h2A); wr_freq(1000); go(0, 0);
    chk("R4 no kill at start", kill, 0);
    cyc(5); chk("R3 hold", cur_freq, 1000);
    cyc(1); chk("R3 step1", cur_freq, 1250);
    cyc(6); chk("R3 step2", cur_freq, 1562);
    cyc(6); chk("R3 step3", cur_freq, 1952);
    chk("R4 kill on overflow", kill, 1);
    cyc(1); chk("R4 kill one cycle", kill, 0);
    cyc(12); chk("R4 frozen after kill", cur_freq, 1952);

    // R7 slow clock select: P=10
    mod_en = 0; wr_swp(8'h9B); wr_freq(100); go(0, 0);
    cyc(9); chk("R7 slow hold", cur_freq, 100);
    cyc(1); chk("R7 slow step", cur_freq, 112);

    // R3/R4/R7 random sweeps
    for (int it = 0; it < 20; it++) begin
      int f, sh, p, e, s;
      bit d;
      logic [7:0] b;
      f = int'($urandom_range(2047, 1)); d = 1'($urandom()); sh = int'($urandom_range(7, 0));
      b = {1'($urandom()), 3'($urandom_range(3, 1)), d, 3'(sh)};
      p = per(b);
      mod_en = 0; wr_swp(b); wr_freq(f); go(0, 0);
      e = f; s = sw_nxt(e, d, sh);
      chk("R4 start kill", kill, (s > 2047) ? 1 : 0);
      if (s > 2047) begin
        cyc(p + 2); chk("R4 frozen", cur_freq, f);
      end else begin
        for (int k = 0; k < 3; k++) begin
          cyc(p - 1); chk("R7 hold to period", cur_freq, e);
          cyc(1); e = s; chk("R3 sweep step", cur_freq, e);
          s = sw_nxt(e, d, sh);
          chk("R4 kill flag", kill, (s > 2047) ? 1 : 0);
          if (s > 2047) break;
        end
      end
    end

    // R5/R6 modulation tables, no repeat then repeat
    mod_en = 0;
    for (int i = 0; i < 32; i++) begin
      tv[i] = 8'($urandom());
      tbl_addr = 5'(i); tbl_data = tv[i]; tbl_we = 1; cyc(1); tbl_we = 0;
    end
    tv[3] = 8'h80; tbl_addr = 3; tbl_data = 8'h80; tbl_we = 1; cyc(1); tbl_we = 0;
    tv[4] = 8'h7F; tbl_addr = 4; tbl_data = 8'h7F; tbl_we = 1; cyc(1); tbl_we = 0;
    for (int rep = 0; rep < 2; rep++) begin
      int f, prev, j;
      f = (rep == 0) ? 60 : 2000;
      mod_en = 0; wr_swp(8'h10); wr_freq(f); go(1, 1'(rep));
      prev = f;
      for (int k = 1; k <= 36; k++) begin
        j = k - 1;
        if (rep == 0) j = (j > 31) ? 31 : j;
        else j = j % 32;
        cyc(2); chk("R5 hold", cur_freq, prev);
        cyc(1); prev = md(f, tv[j]);
        chk(rep == 0 ? "R6 index park" : "R6 index wrap", cur_freq, prev);
        chk("R5 no kill", kill, 0);
      end
    end

    // R9 restart rewinds the table
    mod_en = 0; wr_swp(8'h10); wr_freq(700); go(1, 0);
    cyc(3 * 40);
    go(1, 0);
    cyc(2); chk("R9 restart hold", cur_freq, md(700, tv[31]));
    cyc(1); chk("R9 index rewound", cur_freq, md(700, tv[0]));

    // R8 shorter write takes over, longer write waits
    begin
      int e;
      mod_en = 0; wr_swp(8'hF7); wr_freq(2000); go(0, 0);
      cyc(10);
      wr_swp(8'h17);
      cyc(2); chk("R8 hold after shorten", cur_freq, 2000);
      cyc(1); e = sw_nxt(2000, 0, 7); chk("R8 shortened expiry", cur_freq, e);
      cyc(1);
      wr_swp(8'hF7);
      cyc(1); e = sw_nxt(e, 0, 7); chk("R8 longer write waits", cur_freq, e);
      cyc(69); chk("R8 new period hold", cur_freq, e);
      cyc(1); e = sw_nxt(e, 0, 7); chk("R8 new period step", cur_freq, e);

      // R10 tick gating
      tick = 0; cyc(120); chk("R10 no tick hold", cur_freq, e);
      tick = 1;
      // R7 interval zero freezes
      wr_swp(8'h07); cyc(100); chk("R7 interval zero", cur_freq, e);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule